// File: doc/BRIEF.md
# Serial Audio Pin Function Multiplexer

This block owns three pads of a serial audio port: the receive frame-sync pad and two high-frequency clock pads, one for the receiver and one for the transmitter. Registered configuration bits pick the role of each pad. Each pad can carry its audio function or act as a general-purpose pin. A general-purpose pin is set on its own to input, output or disconnected.

The frame-sync pad has four audio roles. In asynchronous operation it is a frame-sync input or output. In synchronous operation it is a serial flag input or output, or it drives the transmitter's external buffer enable. The flag moves only on a boundary strobe. That strobe is the frame sync in normal mode and the slot strobe in network mode. A clock pad set as an input offers its level to the clock logic as an alternate source and raises a select line. A clock pad set as an output drives the internal high-frequency clock out.

Top module: `sai_pinmux`

## Requirements
- R1: While reset is held and after its release, every pad is disconnected in general-purpose mode. All output enables, pad outputs, general-purpose inputs, alternate-clock selects, the captured flag and the external frame-sync are 0.
- R2: A change on any configuration input shows at the outputs after the next rising clock edge and not before. The configuration inputs are `cfg_pin_func`, `cfg_gpio_mode`, `cfg_gpio_out`, `cfg_sync`, `cfg_bufen`, `cfg_fsr_dir` and `cfg_net` and `cfg_hck_dir`.
- R3: Audio function on pad 0 with `cfg_sync`=0 gives a frame-sync role. With `cfg_fsr_dir`=1 the pad is driven with `int_fs_rx`. With `cfg_fsr_dir`=0 the pad is an input, and `ext_fs_rx` carries its synchronized level.
- R4: With `cfg_sync`=1, `cfg_bufen`=0 and `cfg_fsr_dir`=1, pad 0 is driven from an output-flag register. That register loads `ctl_flag_out` on each boundary strobe and holds its value between strobes.
- R5: With `cfg_sync`=1, `cfg_bufen`=0 and `cfg_fsr_dir`=0, pad 0 is an input. Its synchronized level is stored into `stat_flag_in` on each boundary strobe, and the stored value holds between strobes.
- R6: The boundary strobe is `frame_stb` when `cfg_net`=0 and `slot_stb` when `cfg_net`=1. The other strobe has no effect on either flag.
- R7: With `cfg_sync`=1, `cfg_bufen`=1 and `cfg_fsr_dir`=1, pad 0 is driven with `int_tx_bufen`. With `cfg_fsr_dir`=0 in this mode, the pad is not driven and its level is ignored: no flag capture, and `ext_fs_rx`=0.
- R8: For a pad with `cfg_pin_func` bit 0, its 2-bit field in `cfg_gpio_mode` at bits [2p+1:2p] sets the mode. 01 is input: `gpio_in` shows the synchronized pad and the pad is not driven. 10 is output: the pad is driven with `cfg_gpio_out`. 00 and 11 are disconnected: not driven and `gpio_in`=0. A pad in audio function reads 0 on `gpio_in`.
- R9: Audio function on a clock pad p (1 = receive, 2 = transmit) is controlled by `cfg_hck_dir[p-1]`. With the bit at 1, the pad is driven with `int_hf_clk[p-1]`. With the bit at 0, `alt_clk_sel[p-1]`=1 and `alt_clk[p-1]` follows the pad with no register. Otherwise both are 0.
- R10: The synchronized pad levels used by `gpio_in`, `ext_fs_rx` and flag capture are the pad level two rising edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pin_func | input | 3 | Per pad: 1 = audio function, 0 = general purpose (bit 0 frame-sync pad, 1 receive clock, 2 transmit clock) |
| cfg_gpio_mode | input | 6 | Two bits per pad: 01 input, 10 output, 00/11 disconnected |
| cfg_gpio_out | input | 3 | General-purpose output values |
| cfg_sync | input | 1 | Synchronous operation select |
| cfg_bufen | input | 1 | Buffer-enable role select in synchronous operation |
| cfg_fsr_dir | input | 1 | Frame-sync pad direction, 1 = drive |
| cfg_net | input | 1 | Network mode: flag boundary on slot strobe |
| cfg_hck_dir | input | 2 | Clock pad direction, 1 = drive |
| ctl_flag_out | input | 1 | Output flag value from the control register |
| stat_flag_in | output | 1 | Captured input flag for the status register |
| frame_stb | input | 1 | Internal frame boundary strobe |
| slot_stb | input | 1 | Internal slot boundary strobe |
| int_fs_rx | input | 1 | Internal receive frame sync to drive out |
| int_tx_bufen | input | 1 | Internal transmit buffer enable to drive out |
| int_hf_clk | input | 2 | Internal high-frequency clocks to drive out |
| pad_in | input | 3 | Pad input levels |
| pad_out | output | 3 | Pad output values (0 when not driven) |
| pad_oe | output | 3 | Pad output enables |
| ext_fs_rx | output | 1 | Synchronized external frame sync |
| gpio_in | output | 3 | General-purpose input values |
| alt_clk | output | 2 | Alternate clock from clock pads |
| alt_clk_sel | output | 2 | Alternate clock select for receive/transmit |

## Verification
The assertions assume that the strobes and the configuration inputs are clean, synchronous core-domain signals. They also assume that reset is released away from a strobe. The pad levels alone may be asynchronous. The stimulus changes every input only on the falling clock edge. It keeps the configuration fixed across runs of eight cycles, except in one phase that changes it every cycle to exercise the one-edge latency. The strobes are random, so boundary and non-boundary cycles are mixed in every flag mode.

// File: rtl/sai_pinmux_pkg.sv
package sai_pinmux_pkg;

   localparam int GPIO_MODE_W = 2;

   typedef enum logic [1:0] {
      GPM_OFF     = 2'b00,
      GPM_IN      = 2'b01,
      GPM_OUT     = 2'b10,
      GPM_OFF_ALT = 2'b11
   } gpio_mode_e;

   typedef enum logic [2:0] {
      FSR_FS_IN,
      FSR_FS_OUT,
      FSR_FLAG_IN,
      FSR_FLAG_OUT,
      FSR_BUF_EN,
      FSR_IDLE
   } fsr_role_e;

   typedef struct packed {
      logic sync_mode;
      logic buf_mode;
      logic drive;
      logic net_mode;
   } fsr_cfg_t;

   // Role of the frame-sync pad from the mode bits.
   function automatic fsr_role_e fsr_role(input fsr_cfg_t c);
      if (!c.sync_mode)
         return c.drive ? FSR_FS_OUT : FSR_FS_IN;
      if (!c.buf_mode)
         return c.drive ? FSR_FLAG_OUT : FSR_FLAG_IN;
      return c.drive ? FSR_BUF_EN : FSR_IDLE;
   endfunction

endpackage

// File: rtl/sai_pin_sync.sv
module sai_pin_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sai_pin_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("sai_pin_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stage [STAGES];

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[k] <= '0;
            else        stage[k] <= d;
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[k] <= '0;
            else        stage[k] <= stage[k-1];
         end
      end
   end

   assign q = stage[STAGES-1];

endmodule

// File: rtl/sai_fsr_ctrl.sv
module sai_fsr_ctrl
   import sai_pinmux_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     func_en,
   input  fsr_cfg_t cfg,
   input  logic     flag_val,
   input  logic     frame_stb,
   input  logic     slot_stb,
   input  logic     int_fs,
   input  logic     int_bufen,
   input  logic     pin_sync,
   output logic     fn_out,
   output logic     fn_oe,
   output logic     ext_fs,
   output logic     flag_in
);

   fsr_role_e role;
   logic      bnd;
   logic      of_q;
   logic      if_q;
   logic      capture;

   assign role    = fsr_role(cfg);
   assign bnd     = cfg.net_mode ? slot_stb : frame_stb;
   assign capture = func_en && (role == FSR_FLAG_IN) && bnd;

   // Output flag register: loads only on a boundary strobe.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   of_q <= 1'b0;
      else if (bnd) of_q <= flag_val;
   end

   // Input flag register: pad level captured on a boundary strobe.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       if_q <= 1'b0;
      else if (capture) if_q <= pin_sync;
   end

   always_comb begin
      fn_oe  = 1'b0;
      fn_out = 1'b0;
      ext_fs = 1'b0;
      unique case (role)
         FSR_FS_IN:    ext_fs = func_en & pin_sync;
         FSR_FS_OUT:   begin fn_oe = 1'b1; fn_out = int_fs;    end
         FSR_FLAG_OUT: begin fn_oe = 1'b1; fn_out = of_q;      end
         FSR_BUF_EN:   begin fn_oe = 1'b1; fn_out = int_bufen; end
         FSR_FLAG_IN,
         FSR_IDLE:     ;
         default:      ;
      endcase
   end

   assign flag_in = if_q;

   // R4: the output flag does not move between boundary strobes
   p_oflag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !bnd |=> $stable(of_q));

   // R5: the captured flag does not move without a strobe
   p_iflag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !bnd |=> $stable(flag_in));

   // R6: in network mode a frame strobe alone leaves the output flag alone
   p_net_ignores_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.net_mode && frame_stb && !slot_stb) |=> $stable(of_q));

   // R7: the idle buffer-enable role never drives the pad nor reports a sync
   p_bufen_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.sync_mode && cfg.buf_mode && !cfg.drive) |-> (!fn_oe && !ext_fs));

endmodule

// File: rtl/sai_hck_ctrl.sv
module sai_hck_ctrl (
   input  logic func_en,
   input  logic drive,
   input  logic pad_in,
   input  logic int_clk,
   output logic fn_out,
   output logic fn_oe,
   output logic alt_clk,
   output logic alt_sel
);

   assign fn_oe   = drive;
   assign fn_out  = drive & int_clk;
   assign alt_sel = func_en & ~drive;
   assign alt_clk = alt_sel & pad_in;

endmodule

// File: rtl/sai_pad_cell.sv
module sai_pad_cell
   import sai_pinmux_pkg::*;
(
   input  logic                   func_en,
   input  logic [GPIO_MODE_W-1:0] mode,
   input  logic                   gout,
   input  logic                   sin,
   input  logic                   fn_out,
   input  logic                   fn_oe,
   output logic                   pad_out,
   output logic                   pad_oe,
   output logic                   gin
);

   gpio_mode_e gm;
   assign gm = gpio_mode_e'(mode);

   always_comb begin
      pad_oe  = 1'b0;
      pad_out = 1'b0;
      gin     = 1'b0;
      if (func_en) begin
         pad_oe  = fn_oe;
         pad_out = fn_oe & fn_out;
      end else begin
         unique case (gm)
            GPM_IN:  gin = sin;
            GPM_OUT: begin pad_oe = 1'b1; pad_out = gout; end
            GPM_OFF,
            GPM_OFF_ALT: ;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/sai_pinmux.sv
module sai_pinmux
   import sai_pinmux_pkg::*;
#(
   parameter  int NUM_HCK     = 2,
   parameter  int SYNC_STAGES = 2,
   localparam int NPINS       = NUM_HCK + 1,
   localparam int MODE_BITS   = NPINS * GPIO_MODE_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NPINS-1:0]     cfg_pin_func,
   input  logic [MODE_BITS-1:0] cfg_gpio_mode,
   input  logic [NPINS-1:0]     cfg_gpio_out,
   input  logic                 cfg_sync,
   input  logic                 cfg_bufen,
   input  logic                 cfg_fsr_dir,
   input  logic                 cfg_net,
   input  logic [NUM_HCK-1:0]   cfg_hck_dir,
   input  logic                 ctl_flag_out,
   output logic                 stat_flag_in,
   input  logic                 frame_stb,
   input  logic                 slot_stb,
   input  logic                 int_fs_rx,
   input  logic                 int_tx_bufen,
   input  logic [NUM_HCK-1:0]   int_hf_clk,
   input  logic [NPINS-1:0]     pad_in,
   output logic [NPINS-1:0]     pad_out,
   output logic [NPINS-1:0]     pad_oe,
   output logic                 ext_fs_rx,
   output logic [NPINS-1:0]     gpio_in,
   output logic [NUM_HCK-1:0]   alt_clk,
   output logic [NUM_HCK-1:0]   alt_clk_sel
);

   if (NUM_HCK < 1) begin : g_bad_hck
      $error("sai_pinmux: NUM_HCK must be at least 1");
   end

   // Configuration registers: reset to general-purpose, disconnected.
   logic [NPINS-1:0]     func_q;
   logic [MODE_BITS-1:0] gmode_q;
   logic [NPINS-1:0]     gout_q;
   logic [NUM_HCK-1:0]   hdir_q;
   fsr_cfg_t             fcfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         func_q  <= '0;
         gmode_q <= '0;
         gout_q  <= '0;
         hdir_q  <= '0;
         fcfg_q  <= '0;
      end else begin
         func_q  <= cfg_pin_func;
         gmode_q <= cfg_gpio_mode;
         gout_q  <= cfg_gpio_out;
         hdir_q  <= cfg_hck_dir;
         fcfg_q  <= '{sync_mode: cfg_sync, buf_mode: cfg_bufen,
                      drive: cfg_fsr_dir, net_mode: cfg_net};
      end
   end

   logic [NPINS-1:0] pin_s;

   sai_pin_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pin_s)
   );

   logic [NPINS-1:0] fn_out;
   logic [NPINS-1:0] fn_oe;

   sai_fsr_ctrl u_fsr (
      .clk       (clk),
      .rst_n     (rst_n),
      .func_en   (func_q[0]),
      .cfg       (fcfg_q),
      .flag_val  (ctl_flag_out),
      .frame_stb (frame_stb),
      .slot_stb  (slot_stb),
      .int_fs    (int_fs_rx),
      .int_bufen (int_tx_bufen),
      .pin_sync  (pin_s[0]),
      .fn_out    (fn_out[0]),
      .fn_oe     (fn_oe[0]),
      .ext_fs    (ext_fs_rx),
      .flag_in   (stat_flag_in)
   );

   for (genvar h = 0; h < NUM_HCK; h++) begin : g_hck
      sai_hck_ctrl u_hck (
         .func_en (func_q[h+1]),
         .drive   (hdir_q[h]),
         .pad_in  (pad_in[h+1]),
         .int_clk (int_hf_clk[h]),
         .fn_out  (fn_out[h+1]),
         .fn_oe   (fn_oe[h+1]),
         .alt_clk (alt_clk[h]),
         .alt_sel (alt_clk_sel[h])
      );

      // R9: a pad used as a clock source is never driven at the same time
      p_alt_not_driven_r9: assert property (@(posedge clk) disable iff (!rst_n)
         alt_clk_sel[h] |-> !pad_oe[h+1]);
   end

   for (genvar p = 0; p < NPINS; p++) begin : g_pad
      sai_pad_cell u_cell (
         .func_en (func_q[p]),
         .mode    (gmode_q[p*GPIO_MODE_W +: GPIO_MODE_W]),
         .gout    (gout_q[p]),
         .sin     (pin_s[p]),
         .fn_out  (fn_out[p]),
         .fn_oe   (fn_oe[p]),
         .pad_out (pad_out[p]),
         .pad_oe  (pad_oe[p]),
         .gin     (gpio_in[p])
      );

      // R8: a disconnected general-purpose pad is quiet on both sides
      p_gpio_disc_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (!func_q[p] && (gmode_q[p*GPIO_MODE_W +: GPIO_MODE_W] inside {2'b00, 2'b11}))
         |-> (!pad_oe[p] && !gpio_in[p] && !pad_out[p]));

      // R8: an audio-function pad never reports a general-purpose input
      p_func_no_gpio_r8: assert property (@(posedge clk) disable iff (!rst_n)
         func_q[p] |-> !gpio_in[p]);
   end

   // R1: first cycle after reset release: every pad is released
   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (pad_oe == '0 && alt_clk_sel == '0 && !stat_flag_in));

endmodule

// File: tb/tb_sai_pinmux.sv
module tb_sai_pinmux;

   localparam int CLK_PERIOD = 10;
   localparam int NPH = 11;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cfg_pin_func = '0;
   logic [5:0] cfg_gpio_mode = '0;
   logic [2:0] cfg_gpio_out = '0;
   logic       cfg_sync = 0, cfg_bufen = 0, cfg_fsr_dir = 0, cfg_net = 0;
   logic [1:0] cfg_hck_dir = '0;
   logic       ctl_flag_out = 0;
   logic       stat_flag_in;
   logic       frame_stb = 0, slot_stb = 0, int_fs_rx = 0, int_tx_bufen = 0;
   logic [1:0] int_hf_clk = '0;
   logic [2:0] pad_in = '0;
   logic [2:0] pad_out, pad_oe, gpio_in;
   logic       ext_fs_rx;
   logic [1:0] alt_clk, alt_clk_sel;

   int n_vec = 0;
   int n_bad = 0;
   string tag = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   sai_pinmux dut (
      .clk(clk), .rst_n(rst_n), .cfg_pin_func(cfg_pin_func),
      .cfg_gpio_mode(cfg_gpio_mode), .cfg_gpio_out(cfg_gpio_out),
      .cfg_sync(cfg_sync), .cfg_bufen(cfg_bufen), .cfg_fsr_dir(cfg_fsr_dir),
      .cfg_net(cfg_net), .cfg_hck_dir(cfg_hck_dir), .ctl_flag_out(ctl_flag_out),
      .stat_flag_in(stat_flag_in), .frame_stb(frame_stb), .slot_stb(slot_stb),
      .int_fs_rx(int_fs_rx), .int_tx_bufen(int_tx_bufen), .int_hf_clk(int_hf_clk),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .ext_fs_rx(ext_fs_rx),
      .gpio_in(gpio_in), .alt_clk(alt_clk), .alt_clk_sel(alt_clk_sel)
   );

   // Reference model state, written from the requirements.
   logic [2:0] m_func, m_gout;
   logic [5:0] m_gmode;
   logic       m_sync, m_bufen, m_dir, m_net, m_of, m_if;
   logic [1:0] m_hdir;
   logic [2:0] sync_q [$];
   logic [2:0] e_oe, e_out, e_gin;
   logic       e_ext, e_flag;
   logic [1:0] e_alt, e_sel;

   task automatic model_reset();
      m_func = '0; m_gout = '0; m_gmode = '0; m_hdir = '0;
      m_sync = 0; m_bufen = 0; m_dir = 0; m_net = 0; m_of = 0; m_if = 0;
      sync_q = '{3'b000, 3'b000};
   endtask

   // Pad level seen two edges ago (R10) is the queue head.
   task automatic model_edge();
      logic bnd;
      logic [2:0] seen;
      if (!rst_n) begin
         model_reset();
         return;
      end
      seen = sync_q[0];
      bnd = m_net ? slot_stb : frame_stb;
      if (m_func[0] && m_sync && !m_bufen && !m_dir && bnd) m_if = seen[0];
      if (bnd) m_of = ctl_flag_out;
      void'(sync_q.pop_front());
      sync_q.push_back(pad_in);
      m_func = cfg_pin_func; m_gmode = cfg_gpio_mode; m_gout = cfg_gpio_out;
      m_sync = cfg_sync; m_bufen = cfg_bufen; m_dir = cfg_fsr_dir;
      m_net = cfg_net; m_hdir = cfg_hck_dir;
   endtask

   task automatic expect_now();
      logic [2:0] seen;
      seen = sync_q[0];
      e_oe = '0; e_out = '0; e_gin = '0; e_ext = 0; e_alt = '0; e_sel = '0;
      for (int p = 0; p < 3; p++) begin
         if (m_func[p]) begin
            if (p == 0) begin
               if (!m_sync) begin
                  if (m_dir) begin e_oe[0] = 1; e_out[0] = int_fs_rx; end
                  else e_ext = seen[0];
               end else if (!m_bufen) begin
                  if (m_dir) begin e_oe[0] = 1; e_out[0] = m_of; end
               end else if (m_dir) begin
                  e_oe[0] = 1; e_out[0] = int_tx_bufen;
               end
            end else if (m_hdir[p-1]) begin
               e_oe[p] = 1; e_out[p] = int_hf_clk[p-1];
            end else begin
               e_sel[p-1] = 1; e_alt[p-1] = pad_in[p];
            end
         end else begin
            case (m_gmode[2*p +: 2])
               2'b01:   e_gin[p] = seen[p];
               2'b10:   begin e_oe[p] = 1; e_out[p] = m_gout[p]; end
               default: ;
            endcase
         end
      end
      e_flag = m_if;
   endtask

   task automatic check(string what, logic [2:0] act, logic [2:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s at %0t: actual=%b expected=%b", tag, what, $time, act, exp);
      end
   endtask

   task automatic compare_all();
      expect_now();
      check("pad_oe",       pad_oe,               e_oe);
      check("pad_out",      pad_out,              e_out);
      check("gpio_in",      gpio_in,              e_gin);
      check("ext_fs_rx",    {2'b0, ext_fs_rx},    {2'b0, e_ext});
      check("stat_flag_in", {2'b0, stat_flag_in}, {2'b0, e_flag});
      check("alt_clk",      {1'b0, alt_clk},      {1'b0, e_alt});
      check("alt_clk_sel",  {1'b0, alt_clk_sel},  {1'b0, e_sel});
   endtask

   // Phase stimulus: random data, configuration constrained per requirement.
   task automatic drive(int ph, int cyc);
      pad_in = 3'($urandom); ctl_flag_out = 1'($urandom);
      frame_stb = (($urandom % 4) == 0); slot_stb = (($urandom % 3) == 0);
      int_fs_rx = 1'($urandom); int_tx_bufen = 1'($urandom);
      int_hf_clk = 2'($urandom); cfg_gpio_out = 3'($urandom);
      if (ph == 1 || (cyc % 8) == 0) begin
         cfg_pin_func = 3'($urandom); cfg_gpio_mode = 6'($urandom);
         cfg_sync = 1'($urandom); cfg_bufen = 1'($urandom);
         cfg_fsr_dir = 1'($urandom); cfg_net = 1'($urandom);
         cfg_hck_dir = 2'($urandom);
      end
      case (ph)
         2: begin cfg_pin_func[0] = 1; cfg_sync = 0; end                         // R3
         3: begin cfg_pin_func[0] = 1; cfg_sync = 1; cfg_bufen = 0;
                  cfg_fsr_dir = 1; cfg_net = 0; end                              // R4
         4: begin cfg_pin_func[0] = 1; cfg_sync = 1; cfg_bufen = 0;
                  cfg_fsr_dir = 0; cfg_net = 0; end                              // R5
         5: begin cfg_pin_func[0] = 1; cfg_sync = 1; cfg_bufen = 0; cfg_net = 1; end // R6
         6: begin cfg_pin_func[0] = 1; cfg_sync = 1; cfg_bufen = 1; end          // R7
         7: cfg_pin_func = 3'b000;                                               // R8
         8: cfg_pin_func[2:1] = 2'b11;                                           // R9
         9: begin cfg_pin_func = 3'b000; cfg_gpio_mode = 6'b010101; end          // R10
         default: ;
      endcase
   endtask

   initial begin
      string tags [NPH];
      int    lens [NPH];
      tags = '{"R1", "R2", "R3", "R4", "R5", "R6", "R7", "R8", "R9", "R10", "R2"};
      lens = '{6, 96, 64, 64, 64, 96, 64, 64, 64, 64, 240};
      model_reset();
      @(posedge clk);
      model_edge();
      for (int ph = 0; ph < NPH; ph++) begin
         tag = tags[ph];
         for (int cyc = 0; cyc < lens[ph]; cyc++) begin
            @(negedge clk);
            rst_n = (ph != 0);
            drive(ph, cyc);
            #1;
            compare_all();
            @(posedge clk);
            model_edge();
         end
      end
      @(negedge clk);
      tag = "R2";
      #1;
      compare_all();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule